// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block tracks a single hardware loop for a simple in-order processor, so that a counted loop body repeats without a branch instruction at its end. A setup command loads the first address of the body, the address of its last instruction and an iteration count. From then on the controller watches the program counter that each retiring instruction produces.

When a retiring instruction's next program counter equals the stored end address, the remaining count drops by one. If passes remain, the controller asks fetch, in the same cycle, to go to the stored top address. On the final pass it issues no redirect, so execution falls through past the body, and the loop goes inactive. The loop-back therefore costs no cycles, because the decision is made from the address compare alone and no jump is executed.

All addresses are instruction word addresses. Nested loops and interrupts are outside this block.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset, and while `rst_ni` is low, `loop_active_o` and `redirect_valid_o` are 0. The stored top, end and count are zero.
- R2: A setup command with a nonzero count sets `loop_active_o` to 1 from the next clock edge.
- R3: A setup command with a count of 0 leaves `loop_active_o` at 0. No later retirement at the given end address causes a redirect.
- R4: Suppose the loop is active, `retire_valid_i` is 1, `next_pc_i` equals the stored end address and the remaining count is greater than 1. Then `redirect_valid_o` is 1 in that same cycle, `redirect_pc_o` equals the stored top address, and the count drops by one at the clock edge.
- R5: Suppose the loop is active and a match occurs with a remaining count of 1. Then no redirect is issued, and `loop_active_o` is 0 from the next clock edge.
- R6: A retirement whose `next_pc_i` differs from the end address causes no redirect and leaves the count unchanged.
- R7: When `retire_valid_i` is 0, `next_pc_i` is ignored: there is no redirect and no count change.
- R8: A setup command in the same cycle as a match has priority. No redirect is issued that cycle, and the new top, end and count replace the old ones.
- R9: A loop set up with count N issues exactly N-1 redirects, and goes inactive on the N-th match.
- R10: A setup command while a loop is active replaces the loop. The old end address no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | Load a new loop this cycle |
| setup_top_i | input | ADDR_W | First word address of the loop body |
| setup_end_i | input | ADDR_W | Word address whose match ends a pass |
| setup_count_i | input | CNT_W | Number of passes (0 means no loop) |
| retire_valid_i | input | 1 | An instruction completes this cycle |
| next_pc_i | input | ADDR_W | Program counter after the retiring instruction |
| redirect_valid_o | output | 1 | Fetch must go to `redirect_pc_o` |
| redirect_pc_o | output | ADDR_W | Loop top address |
| loop_active_o | output | 1 | A loop is in progress |

## Verification
The assertions assume that the counter is never asked to decrement while it holds zero. In other words, they rely on an active loop always having passes left. They also assume that the processor presents at most one retirement per cycle, with `next_pc_i` stable while `retire_valid_i` is high.

The stimulus keeps to these assumptions. It retires at most one instruction per cycle, and it only reaches the end address of a loop set up with a nonzero count. A stale end address is probed only after its loop has exited or been replaced.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef struct packed {
    logic hit;   // qualified end-address match
    logic last;  // match consumes the final pass
  } hwl_event_t;
endpackage

// File: rtl/hwl_addr_regs.sv
module hwl_addr_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] top_o,
  output logic [ADDR_W-1:0] end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_o <= '0;
      end_o <= '0;
    end else if (load_i) begin
      top_o <= top_i;
      end_o <= end_i;
    end
  end

  p_load_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> end_o == $past(end_i));
endmodule

// File: rtl/hwl_down_cnt.sv
module hwl_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i)   cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);
  assign zero_o = (cnt_q == '0);

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
  p_dec_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hwl_match.sv
module hwl_match #(
  parameter int ADDR_W = 16
) (
  input  logic              retire_i,
  input  logic              active_i,
  input  logic              setup_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] end_i,
  output hwl_pkg::hwl_event_t ev_o
);
  always_comb begin
    ev_o.hit  = retire_i && active_i && !setup_i && (pc_i == end_i);
    ev_o.last = ev_o.hit && last_i;
  end
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_valid_i,
  input  logic [ADDR_W-1:0] setup_top_i,
  input  logic [ADDR_W-1:0] setup_end_i,
  input  logic [CNT_W-1:0]  setup_count_i,
  input  logic              retire_valid_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic              loop_active_o
);
  import hwl_pkg::*;

  logic [ADDR_W-1:0] top_q, end_q;
  logic              cnt_last, cnt_zero;
  logic              active_q;
  hwl_event_t        ev;

  hwl_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(setup_valid_i),
    .top_i (setup_top_i),
    .end_i (setup_end_i),
    .top_o (top_q),
    .end_o (end_q)
  );

  hwl_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (setup_valid_i),
    .load_val_i(setup_count_i),
    .dec_i     (ev.hit),
    .last_o    (cnt_last),
    .zero_o    (cnt_zero)
  );

  hwl_match #(.ADDR_W(ADDR_W)) u_match (
    .retire_i(retire_valid_i),
    .active_i(active_q),
    .setup_i (setup_valid_i),
    .last_i  (cnt_last),
    .pc_i    (next_pc_i),
    .end_i   (end_q),
    .ev_o    (ev)
  );

  // setup has priority over an exiting match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            active_q <= 1'b0;
    else if (setup_valid_i) active_q <= (setup_count_i != '0);
    else if (ev.last)       active_q <= 1'b0;
  end

  assign redirect_valid_o = ev.hit && !ev.last;
  assign redirect_pc_o    = top_q;
  assign loop_active_o    = active_q;

  p_live_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> !cnt_zero);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_valid_i && setup_count_i != '0) |=> loop_active_o);
  p_zero_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_valid_i && setup_count_i == '0) |=> !loop_active_o);
  p_redirect_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> loop_active_o);
  p_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev.last && !setup_valid_i) |=> !loop_active_o);
  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |-> !redirect_valid_o);
  p_setup_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_valid_i |-> !redirect_valid_o);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!loop_active_o && !redirect_valid_o));
endmodule

// File: tb/hw_loop_ctrl_tb_top.sv
module hw_loop_ctrl_tb_top;
  localparam int AW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic          su;
    logic [AW-1:0] top;
    logic [AW-1:0] fin;
    logic [CW-1:0] cnt;
    logic          ret;
    logic [AW-1:0] pc;
    logic          e_rv;
    logic [AW-1:0] e_rpc;
    logic          e_act;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 8'd1},  // R1 idle
    '{1'b1, 16'h000A, 16'h000E, 16'd3, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd2},  // R2 start
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h000B, 1'b0, 16'h0000, 1'b1, 8'd6},  // R6 other pc
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b0, 16'h000E, 1'b0, 16'h0000, 1'b1, 8'd7},  // R7 no retire
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h000E, 1'b1, 16'h000A, 1'b1, 8'd4},  // R4 3->2
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h000E, 1'b1, 16'h000A, 1'b1, 8'd4},  // R4 2->1
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h000E, 1'b0, 16'h0000, 1'b0, 8'd5},  // R5 exit
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h000E, 1'b0, 16'h0000, 1'b0, 8'd5},  // R5 stays off
    '{1'b1, 16'h0005, 16'h000E, 16'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 8'd3},  // R3 zero count
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h000E, 1'b0, 16'h0000, 1'b0, 8'd3},  // R3 no redirect
    '{1'b1, 16'h0100, 16'h0103, 16'd1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd9},  // R9 count 1
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h0103, 1'b0, 16'h0000, 1'b0, 8'd9},  // R9 no redirect
    '{1'b1, 16'h0014, 16'h001E, 16'd2, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd2},
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h001E, 1'b1, 16'h0014, 1'b1, 8'd4},  // 2->1
    '{1'b1, 16'h0028, 16'h0032, 16'd2, 1'b1, 16'h001E, 1'b0, 16'h0000, 1'b1, 8'd8},  // R8 setup wins
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h001E, 1'b0, 16'h0000, 1'b1, 8'd10}, // R10 old end dead
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h0032, 1'b1, 16'h0028, 1'b1, 8'd10}, // R10 new loop
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'h0032, 1'b0, 16'h0000, 1'b0, 8'd9},  // R9 count 2
    '{1'b1, 16'hFFF0, 16'hFFFF, 16'd2, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd2},
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'hFFFF, 1'b1, 16'hFFF0, 1'b1, 8'd4},  // R4 top of space
    '{1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd5}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          setup_valid_i = 1'b0;
  logic [AW-1:0] setup_top_i = '0;
  logic [AW-1:0] setup_end_i = '0;
  logic [CW-1:0] setup_count_i = '0;
  logic          retire_valid_i = 1'b0;
  logic [AW-1:0] next_pc_i = '0;
  logic          redirect_valid_o;
  logic [AW-1:0] redirect_pc_o;
  logic          loop_active_o;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hw_loop_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .setup_valid_i   (setup_valid_i),
    .setup_top_i     (setup_top_i),
    .setup_end_i     (setup_end_i),
    .setup_count_i   (setup_count_i),
    .retire_valid_i  (retire_valid_i),
    .next_pc_i       (next_pc_i),
    .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o   (redirect_pc_o),
    .loop_active_o   (loop_active_o)
  );

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("active in reset", 1, 32'(loop_active_o), 0);
    check("redirect in reset", 1, 32'(redirect_valid_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      setup_valid_i  = VECS[i].su;
      setup_top_i    = VECS[i].top;
      setup_end_i    = VECS[i].fin;
      setup_count_i  = VECS[i].cnt;
      retire_valid_i = VECS[i].ret;
      next_pc_i      = VECS[i].pc;
      #1;
      check($sformatf("vec %0d redirect", i), int'(VECS[i].req),
            32'(redirect_valid_o), 32'(VECS[i].e_rv));
      if (VECS[i].e_rv)
        check($sformatf("vec %0d target", i), int'(VECS[i].req),
              32'(redirect_pc_o), 32'(VECS[i].e_rpc));
      @(posedge clk_i);
      #1;
      check($sformatf("vec %0d active", i), int'(VECS[i].req),
            32'(loop_active_o), 32'(VECS[i].e_act));
    end

    // R1: asynchronous reset in mid-loop clears everything
    @(negedge clk_i);
    setup_valid_i = 1'b1; setup_top_i = 16'h0200; setup_end_i = 16'h0210;
    setup_count_i = 16'd5; retire_valid_i = 1'b0;
    @(negedge clk_i);
    setup_valid_i = 1'b0;
    check("active before reset", 1, 32'(loop_active_o), 1);
    rst_ni = 1'b0;
    #1;
    check("active after async reset", 1, 32'(loop_active_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    retire_valid_i = 1'b1; next_pc_i = 16'h0210;
    #1;
    check("no redirect after reset", 1, 32'(redirect_valid_o), 0);
    // R1: stored end cleared to zero, still inactive so pc 0 gives nothing
    next_pc_i = 16'h0000;
    #1;
    check("no redirect at pc 0", 1, 32'(redirect_valid_o), 0);

    // R9: count 4 gives exactly 3 redirects, with non-matching retirements between
    @(negedge clk_i);
    retire_valid_i = 1'b0;
    setup_valid_i = 1'b1; setup_top_i = 16'h0300; setup_end_i = 16'h0304;
    setup_count_i = 16'd4;
    @(negedge clk_i);
    setup_valid_i = 1'b0;
    begin
      int redirects = 0;
      for (int k = 0; k < 8; k++) begin
        retire_valid_i = 1'b1;
        next_pc_i = (k % 2 == 0) ? 16'h0302 : 16'h0304;
        #1;
        if (redirect_valid_o) redirects++;
        @(negedge clk_i);
      end
      retire_valid_i = 1'b0;
      check("redirect count for 4 passes", 9, 32'(redirects), 3);
      check("inactive after 4 passes", 9, 32'(loop_active_o), 0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule